// File: doc/BRIEF.md
# Two-Speed Start-Up Sequencer

This block chooses the clock source the core runs from after power-on or a wake from sleep. When the configured source is an external crystal oscillator, a start-up counter clocked by that oscillator counts 1024 of its cycles before the oscillator counts as stable. Until then the core either waits in a stall or, in two-speed mode, runs from the internal oscillator. It moves to the external source only when the count is complete.

The block makes no clocks. It drives a source request to a separate clock switch, a status bit that reports a stable external oscillator, and a stall line to the core. A sleep request stops any count in progress and clears the status. A later wake runs the whole sequence again, with the count starting from zero.

Top module: `clkstart_seq`

## Requirements
- R1: After launch in a crystal mode, `ext_stable` rises no earlier than 1024 and no later than 1032 rising edges of `clk_ext`. Launch is the first `clk_int` edge at which `pwrt_done` is seen high. Once `ext_stable` is high, `src_ext_req` is also high.
- R2: The mode field `cfg_osc_mode` selects a crystal mode with codes 3'b000 (low power), 3'b001 (crystal) and 3'b010 (high speed). Any other code is an internal mode. In an internal mode, `core_stall` is low one `clk_int` cycle after launch, and `src_ext_req` and `ext_stable` stay low.
- R3: In a crystal mode without two-speed operation, `core_stall` stays high from launch until the count completes. `core_stall` then falls in the same cycle that `src_ext_req` and `ext_stable` rise.
- R4: With two-speed operation, `core_stall` is low one `clk_int` cycle after launch and `src_ext_req` stays low while the count runs. At the end of the count, `src_ext_req` and `ext_stable` rise.
- R5: Two-speed operation needs all three conditions at once: `cfg_twospeed_en` = 1, `cfg_clk_sel` = 2'b00, and a crystal mode. If any one is missing, a crystal mode behaves as in R3.
- R6: While `rst_n` is low, and after reset until `pwrt_done` is high, `core_stall` = 1, `src_ext_req` = 0 and `ext_stable` = 0.
- R7: A `sleep_req` pulse during a count gives `core_stall` = 1, `ext_stable` = 0 and `src_ext_req` = 0 one cycle later. The count is abandoned, and `ext_stable` stays low until a wake.
- R8: After sleep, a `wake_evt` pulse relaunches the sequence for the current configuration. Any count starts again from zero, so a full 1024 external cycles pass before `ext_stable` rises.
- R9: A `sleep_req` pulse while the core runs, from either source, gives `core_stall` = 1 and `src_ext_req` = 0 one cycle later. A `wake_evt` pulse outside sleep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; the control logic runs on it |
| clk_ext | input | 1 | External oscillator clock; the start-up counter runs on it |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_twospeed_en | input | 1 | Two-speed enable bit |
| cfg_osc_mode | input | 3 | Oscillator mode field |
| cfg_clk_sel | input | 2 | Clock-select field; 2'b00 selects the primary source |
| pwrt_done | input | 1 | Power-up timer expired (tie high if the timer is unused) |
| wake_evt | input | 1 | Wake-from-sleep event, one-cycle pulse |
| sleep_req | input | 1 | Sleep request, one-cycle pulse |
| src_ext_req | output | 1 | Request to the clock switch: 1 selects the external oscillator |
| ext_stable | output | 1 | Status: the external oscillator has completed its start-up count |
| core_stall | output | 1 | Holds the core |

## Verification
Results that stay inside the internal domain, such as the stall after launch, the sleep response and the ignored wake, are due one `clk_int` cycle after the stimulus. The bench drives each stimulus on a falling edge and samples on the next falling edge. The status handover crosses two clock domains, so it has no fixed cycle. The bench counts `clk_ext` edges from launch to the rise of `ext_stable` and checks that count against a window: the full 1024 at the low end, with the synchroniser stages added at the high end. While waiting, it checks `core_stall` on every cycle.

// File: rtl/clkstart_pkg.sv
package clkstart_pkg;

    localparam int MODE_W = 3;
    localparam int SEL_W  = 2;

    localparam logic [MODE_W-1:0] MODE_XTAL_LOWPWR = 3'b000;
    localparam logic [MODE_W-1:0] MODE_XTAL_STD    = 3'b001;
    localparam logic [MODE_W-1:0] MODE_XTAL_FAST   = 3'b010;
    localparam logic [SEL_W-1:0]  SEL_PRIMARY      = 2'b00;

    typedef enum logic [2:0] {
        ST_POR   = 3'd0,  // waiting for the power-up timer
        ST_FAST  = 3'd1,  // counting, core runs from internal clock
        ST_HOLD  = 3'd2,  // counting, core stalled
        ST_EXT   = 3'd3,  // running from external oscillator
        ST_INT   = 3'd4,  // running from internal oscillator, no count
        ST_SLEEP = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       wake_pend;
    } ctrl_reg_t;

    function automatic logic mode_is_xtal(input logic [MODE_W-1:0] m);
        return (m == MODE_XTAL_LOWPWR) || (m == MODE_XTAL_STD) || (m == MODE_XTAL_FAST);
    endfunction

    function automatic logic two_speed_on(input logic en,
                                          input logic [SEL_W-1:0] sel,
                                          input logic [MODE_W-1:0] m);
        return en && (sel == SEL_PRIMARY) && mode_is_xtal(m);
    endfunction

endpackage

// File: rtl/clkstart_sync.sv
module clkstart_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkstart_ost.sv
module clkstart_ost #(
    parameter int OST_COUNT   = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(OST_COUNT + 1)
) (
    input  logic             clk_ext,
    input  logic             rst_n,
    input  logic             run_i,   // from internal domain, async
    output logic             done_o,
    output logic             idle_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OST_COUNT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             idle;
    } ost_reg_t;

    logic     run_s;
    ost_reg_t r_d;
    ost_reg_t r_q;

    clkstart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
        .clk   (clk_ext),
        .rst_n (rst_n),
        .d_i   (run_i),
        .q_o   (run_s)
    );

    always_comb begin
        r_d = r_q;
        if (!run_s) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != LIMIT) begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end
        r_d.done = (r_d.cnt == LIMIT);
        r_d.idle = !run_s && (r_d.cnt == '0);
    end

    always_ff @(posedge clk_ext or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt  <= '0;
            r_q.done <= 1'b0;
            r_q.idle <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
    assign idle_o = r_q.idle;
    assign cnt_o  = r_q.cnt;
endmodule

// File: rtl/clkstart_ctrl.sv
module clkstart_ctrl
    import clkstart_pkg::*;
(
    input  logic              clk_int,
    input  logic              rst_n,
    input  logic              cfg_twospeed_en,
    input  logic [MODE_W-1:0] cfg_osc_mode,
    input  logic [SEL_W-1:0]  cfg_clk_sel,
    input  logic              pwrt_done,
    input  logic              wake_evt,
    input  logic              sleep_req,
    input  logic              done_s,
    input  logic              idle_s,
    output logic              cnt_run,
    output logic              src_ext_req,
    output logic              ext_stable,
    output logic              core_stall
);
    ctrl_reg_t  r_d;
    ctrl_reg_t  r_q;
    seq_state_e launch_st;
    logic       wake_any;

    always_comb begin
        if (!mode_is_xtal(cfg_osc_mode))
            launch_st = ST_INT;
        else if (two_speed_on(cfg_twospeed_en, cfg_clk_sel, cfg_osc_mode))
            launch_st = ST_FAST;
        else
            launch_st = ST_HOLD;
    end

    always_comb begin
        r_d      = r_q;
        wake_any = r_q.wake_pend || wake_evt;
        case (r_q.state)
            ST_POR: begin
                if (pwrt_done) r_d.state = launch_st;
            end
            ST_FAST, ST_HOLD: begin
                if (sleep_req)   r_d.state = ST_SLEEP;
                else if (done_s) r_d.state = ST_EXT;
            end
            ST_EXT, ST_INT: begin
                if (sleep_req) begin
                    r_d.state     = ST_SLEEP;
                    r_d.wake_pend = 1'b0;
                end
            end
            ST_SLEEP: begin
                if (wake_any && idle_s) begin
                    r_d.state     = launch_st;
                    r_d.wake_pend = 1'b0;
                end else begin
                    r_d.wake_pend = wake_any;
                end
            end
            default: r_d.state = ST_POR;
        endcase
    end

    always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_POR;
            r_q.wake_pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_run     = (r_q.state == ST_FAST) || (r_q.state == ST_HOLD) || (r_q.state == ST_EXT);
    assign src_ext_req = (r_q.state == ST_EXT);
    assign ext_stable  = (r_q.state == ST_EXT);
    assign core_stall  = (r_q.state == ST_POR) || (r_q.state == ST_HOLD) || (r_q.state == ST_SLEEP);
endmodule

// File: rtl/clkstart_seq.sv
module clkstart_seq #(
    parameter int OST_COUNT   = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(OST_COUNT + 1)
) (
    input  logic       clk_int,
    input  logic       clk_ext,
    input  logic       rst_n,
    input  logic       cfg_twospeed_en,
    input  logic [2:0] cfg_osc_mode,
    input  logic [1:0] cfg_clk_sel,
    input  logic       pwrt_done,
    input  logic       wake_evt,
    input  logic       sleep_req,
    output logic       src_ext_req,
    output logic       ext_stable,
    output logic       core_stall
);
    logic             cnt_run;
    logic             done_raw;
    logic             idle_raw;
    logic             done_s;
    logic             idle_s;
    logic [CNT_W-1:0] ost_count;

    clkstart_ost #(.OST_COUNT(OST_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_ost (
        .clk_ext (clk_ext),
        .rst_n   (rst_n),
        .run_i   (cnt_run),
        .done_o  (done_raw),
        .idle_o  (idle_raw),
        .cnt_o   (ost_count)
    );

    clkstart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
        .clk   (clk_int),
        .rst_n (rst_n),
        .d_i   (done_raw),
        .q_o   (done_s)
    );

    clkstart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_idle_sync (
        .clk   (clk_int),
        .rst_n (rst_n),
        .d_i   (idle_raw),
        .q_o   (idle_s)
    );

    clkstart_ctrl u_ctrl (
        .clk_int         (clk_int),
        .rst_n           (rst_n),
        .cfg_twospeed_en (cfg_twospeed_en),
        .cfg_osc_mode    (cfg_osc_mode),
        .cfg_clk_sel     (cfg_clk_sel),
        .pwrt_done       (pwrt_done),
        .wake_evt        (wake_evt),
        .sleep_req       (sleep_req),
        .done_s          (done_s),
        .idle_s          (idle_s),
        .cnt_run         (cnt_run),
        .src_ext_req     (src_ext_req),
        .ext_stable      (ext_stable),
        .core_stall      (core_stall)
    );
endmodule

// File: rtl/clkstart_seq_chk.sv
module clkstart_seq_chk #(
    parameter int OST_COUNT = 1024,
    localparam int CNT_W    = $clog2(OST_COUNT + 1)
) (
    input logic             clk_int,
    input logic             clk_ext,
    input logic             rst_n,
    input logic             sleep_req,
    input logic             src_ext_req,
    input logic             ext_stable,
    input logic             core_stall,
    input logic             cnt_run,
    input logic             done_s,
    input logic             idle_s,
    input logic [CNT_W-1:0] ost_count
);
    AST_EXT_AFTER_DONE: assert property (@(posedge clk_int) disable iff (!rst_n)
        src_ext_req |-> done_s);  // R4

    AST_STABLE_AFTER_COUNT: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(ext_stable) |-> $past(cnt_run));  // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk_ext) disable iff (!rst_n)
        ost_count <= CNT_W'(OST_COUNT));  // R1

    AST_SLEEP_ABORT: assert property (@(posedge clk_int) disable iff (!rst_n)
        sleep_req |=> !ext_stable);  // R7

    AST_SLEEP_STALL: assert property (@(posedge clk_int) disable iff (!rst_n)
        (sleep_req && !core_stall) |=> (core_stall && !src_ext_req));  // R9

    AST_LAUNCH_FROM_ZERO: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(cnt_run) |-> (idle_s && !done_s));  // R8
endmodule

bind clkstart_seq clkstart_seq_chk #(.OST_COUNT(OST_COUNT)) u_chk (
    .clk_int     (clk_int),
    .clk_ext     (clk_ext),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .src_ext_req (src_ext_req),
    .ext_stable  (ext_stable),
    .core_stall  (core_stall),
    .cnt_run     (cnt_run),
    .done_s      (done_s),
    .idle_s      (idle_s),
    .ost_count   (ost_count)
);

// File: tb/clkstart_seq_tb_top.sv
`timescale 1ns/1ps
module clkstart_seq_tb_top;
    localparam int COUNT    = 1024;
    localparam int SLACK    = 8;
    localparam int N_VEC    = 8;
    // [7] enable, [6:5] clock select, [4:2] mode, [1] crystal expected, [0] two-speed expected
    localparam logic [7:0] VEC [N_VEC] = '{
        8'b10000011, 8'b10000111, 8'b10001011, 8'b00000110,
        8'b10101010, 8'b11000010, 8'b10010000, 8'b01111100
    };

    logic clk_int = 1'b0;
    logic clk_ext = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_twospeed_en = 1'b0;
    logic [2:0] cfg_osc_mode = 3'b000;
    logic [1:0] cfg_clk_sel = 2'b00;
    logic pwrt_done = 1'b0;
    logic wake_evt = 1'b0;
    logic sleep_req = 1'b0;
    logic src_ext_req;
    logic ext_stable;
    logic core_stall;

    int n_chk = 0;
    int n_bad = 0;
    int ext_edges = 0;

    always #2 clk_int = ~clk_int;
    always #5 clk_ext = ~clk_ext;
    always @(posedge clk_ext) ext_edges <= ext_edges + 1;

    clkstart_seq dut_i (
        .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n),
        .cfg_twospeed_en(cfg_twospeed_en), .cfg_osc_mode(cfg_osc_mode),
        .cfg_clk_sel(cfg_clk_sel), .pwrt_done(pwrt_done),
        .wake_evt(wake_evt), .sleep_req(sleep_req),
        .src_ext_req(src_ext_req), .ext_stable(ext_stable), .core_stall(core_stall)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_int);
        rst_n = 1'b0; pwrt_done = 1'b0; sleep_req = 1'b0; wake_evt = 1'b0;
        repeat (3) @(negedge clk_int);
        check(core_stall && !src_ext_req && !ext_stable, "R6 in reset",
              {29'd0, core_stall, src_ext_req, ext_stable}, 4);
        rst_n = 1'b1;
        repeat (5) @(negedge clk_int);
        check(core_stall && !src_ext_req && !ext_stable, "R6 timer pending",
              {29'd0, core_stall, src_ext_req, ext_stable}, 4);
    endtask

    // Waits for ext_stable; checks stall each cycle; returns external edges since start.
    task automatic wait_stable(input int start, input logic exp_stall, input string req,
                               output int edges);
        int  cyc = 0;
        logic bad = 1'b0;
        while (!ext_stable && cyc < 4000) begin
            if (core_stall != exp_stall || src_ext_req) bad = 1'b1;
            @(negedge clk_int);
            cyc++;
        end
        edges = ext_edges - start;
        check(!bad, req, int'(bad), 0);
        check(ext_stable && src_ext_req && !core_stall, {req, " handover"},
              {29'd0, core_stall, src_ext_req, ext_stable}, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk_int);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int start;
        int edges;
        for (int v = 0; v < N_VEC; v++) begin
            logic xtal, fast;
            cfg_twospeed_en = VEC[v][7];
            cfg_clk_sel     = VEC[v][6:5];
            cfg_osc_mode    = VEC[v][4:2];
            xtal            = VEC[v][1];
            fast            = VEC[v][0];
            do_reset();
            pwrt_done = 1'b1;
            start = ext_edges;
            @(negedge clk_int);
            if (!xtal) begin
                check(!core_stall && !src_ext_req && !ext_stable, "R2 release",
                      {29'd0, core_stall, src_ext_req, ext_stable}, 0);
                repeat (3000) @(negedge clk_int);
                check(!core_stall && !src_ext_req && !ext_stable, "R2 no handover",
                      {29'd0, core_stall, src_ext_req, ext_stable}, 0);
            end else begin
                check(core_stall == !fast, fast ? "R4 fast start" : "R3 R5 hold start",
                      int'(core_stall), int'(!fast));
                wait_stable(start, !fast, fast ? "R4 count" : "R3 R5 count", edges);
                check(edges >= COUNT && edges <= COUNT + SLACK, "R1 count length", edges, COUNT);
            end
        end

        // Sleep aborts a count in progress
        cfg_twospeed_en = 1'b1; cfg_clk_sel = 2'b00; cfg_osc_mode = 3'b001;
        do_reset();
        pwrt_done = 1'b1;
        repeat (300) @(negedge clk_int);
        sleep_req = 1'b1;
        @(negedge clk_int);
        sleep_req = 1'b0;
        check(core_stall && !src_ext_req && !ext_stable, "R7 abort",
              {29'd0, core_stall, src_ext_req, ext_stable}, 4);
        repeat (3000) @(negedge clk_int);
        check(!ext_stable && core_stall, "R7 stays clear", int'(ext_stable), 0);

        // Wake restarts from zero
        wake_evt = 1'b1;
        start = ext_edges;
        @(negedge clk_int);
        wake_evt = 1'b0;
        check(!core_stall && !src_ext_req, "R8 relaunch two-speed", int'(core_stall), 0);
        wait_stable(start, 1'b0, "R8 recount", edges);
        check(edges >= COUNT && edges <= COUNT + SLACK, "R8 full count", edges, COUNT);

        // Wake outside sleep is ignored
        wake_evt = 1'b1;
        @(negedge clk_int);
        wake_evt = 1'b0;
        @(negedge clk_int);
        check(ext_stable && src_ext_req && !core_stall, "R9 stray wake",
              {29'd0, core_stall, src_ext_req, ext_stable}, 3);

        // Sleep while running from external, immediate wake
        sleep_req = 1'b1;
        @(negedge clk_int);
        sleep_req = 1'b0;
        check(core_stall && !src_ext_req && !ext_stable, "R9 sleep from ext",
              {29'd0, core_stall, src_ext_req, ext_stable}, 4);
        wake_evt = 1'b1;
        start = ext_edges;
        @(negedge clk_int);
        wake_evt = 1'b0;
        repeat (20) @(negedge clk_int);
        check(!core_stall && !ext_stable, "R8 relaunch after ext", int'(core_stall), 0);
        wait_stable(start, 1'b0, "R8 recount after ext", edges);
        check(edges >= COUNT && edges <= COUNT + 16, "R8 full count after ext", edges, COUNT);

        // Sleep from internal mode
        cfg_osc_mode = 3'b110;
        do_reset();
        pwrt_done = 1'b1;
        repeat (2) @(negedge clk_int);
        sleep_req = 1'b1;
        @(negedge clk_int);
        sleep_req = 1'b0;
        check(core_stall && !src_ext_req, "R9 sleep from internal", int'(core_stall), 1);
        wake_evt = 1'b1;
        @(negedge clk_int);
        wake_evt = 1'b0;
        check(!core_stall && !ext_stable, "R2 wake internal", int'(core_stall), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule